// File: doc/BRIEF.md
# Prioritised Interrupt Vectoring Unit

This block decides, at each instruction boundary of a small processor core, whether an interrupt is taken and which one. It sees one non-maskable request, three maskable restart requests of fixed rank (called high, middle and low here) and one general request whose target is supplied from outside. It owns the interrupt-enable flag, so the core reports enable and disable instructions to it as single-cycle pulses. When a request wins, the block gives the core a vector address, a flag saying whether the return address must be pushed, and the number of cycles the entry costs.

The core holds `boundary` high for one cycle when an instruction completes. Requests are looked at only in that cycle. The result appears one clock later as a one-cycle `take` pulse, together with the vector, the push flag, the cost and the winning source. All result pins are plain control outputs with no back-pressure. The core must act on the `take` pulse in the cycle it is high. The stack write and the fetch of the general request's instruction are done outside this block. For the general request, the supplied instruction is reduced to a call/jump flag and a 16-bit target.

An enable pulse may come during the enable instruction or in the same cycle as that instruction's own boundary strobe. In both cases, maskable requests stay blocked until the instruction after the enable instruction has completed.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset, `int_en` is 0 and `take` is 0.
- R2: When several requests are eligible at a boundary, exactly one is taken. The order is non-maskable, then `rst_req[2]` (high), then `rst_req[1]` (middle), then `rst_req[0]` (low), then the general request. `take_src` is one-hot with bit 4 for non-maskable, bits 3, 2, 1 for high, middle, low, and bit 0 for general.
- R3: The vector is 0x0024 for non-maskable, 0x003C for high, 0x0034 for middle and 0x002C for low. A `rst_mask` bit at 1 masks the restart request in the same bit position.
- R4: Taking the non-maskable request or any restart request sets `push_pc` and a cost of 11 cycles.
- R5: Taking the general request gives `vector` = `gen_vector`. With `gen_is_call` = 1 it sets `push_pc` and a cost of 17 cycles. With `gen_is_call` = 0 it clears `push_pc` and the cost is 10 cycles.
- R6: The non-maskable request is taken at any boundary, whatever the values of `int_en` and `rst_mask`.
- R7: A restart request is taken only if `int_en` is 1 and its mask bit is 0. The general request is taken only if `int_en` is 1.
- R8: Taking any interrupt clears `int_en`.
- R9: `ei_pulse` sets `int_en`. Maskable requests are refused at the boundary ending the enable instruction, and are accepted again from the following boundary onward. If `ei_pulse` comes before that boundary, it is the next boundary that refuses. If `ei_pulse` comes with that boundary, it is that same boundary that refuses.
- R10: `di_pulse` clears `int_en` in the next cycle. It also refuses maskable requests at a boundary in the same cycle.
- R11: Requests are sampled only when `boundary` is 1. The result is a `take` pulse exactly one cycle later, lasting one cycle. Without `boundary`, `take` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_req | input | 1 | Non-maskable request |
| rst_req | input | 3 | Restart requests: bit 2 high, bit 1 middle, bit 0 low |
| rst_mask | input | 3 | Mask bits, 1 = masked, same bit order as `rst_req` |
| gen_req | input | 1 | General maskable request |
| gen_is_call | input | 1 | Supplied instruction is a call (1) or a jump (0) |
| gen_vector | input | 16 | Target of the supplied instruction |
| ei_pulse | input | 1 | Enable instruction executed |
| di_pulse | input | 1 | Disable instruction executed |
| boundary | input | 1 | Instruction boundary strobe |
| int_en | output | 1 | Interrupt-enable flag |
| take | output | 1 | Interrupt accepted (one-cycle pulse) |
| take_src | output | 5 | One-hot winning source |
| vector | output | 16 | Entry address |
| push_pc | output | 1 | Return address must be pushed |
| cycles | output | 5 | Cycle cost of the entry |

## Verification
The assertions check on every cycle the rules that a property can state. A pulse appears only after a boundary. The winner is one-hot. Acceptance leaves the enable flag clear. Disable clears it. A non-maskable request always wins. Restart entries cost 11 cycles, and the non-maskable vector is fixed. Maskable requests are refused while the flag is clear or in the cycle after an enable pulse. The bench sweeps every mix of the five requests, three masks, enable state and general instruction type, and compares against an arithmetic model. Only its scenarios show the two-boundary hold after an enable pulse that arrives early, and the full vector table under masking.

// File: rtl/irqv_pkg.sv
package irqv_pkg;
  localparam int NRST   = 3;            // restart lines, index NRST-1 ranks highest
  localparam int NSRC   = NRST + 2;     // plus non-maskable and general
  localparam int ADDR_W = 16;
  localparam int CYC_W  = 5;
  localparam int SRC_NMI = NSRC - 1;
  localparam int SRC_GEN = 0;
endpackage

// File: rtl/irqv_arbiter.sv
module irqv_arbiter
  import irqv_pkg::*;
(
  input  logic            nmi,
  input  logic [NRST-1:0] rst_req,
  input  logic [NRST-1:0] rst_mask,
  input  logic            gen_req,
  input  logic            allow,
  output logic [NSRC-1:0] grant
);
  logic [NSRC-1:0] cand;

  assign cand[SRC_NMI] = nmi;
  assign cand[SRC_GEN] = gen_req & allow;

  generate
    for (genvar i = 0; i < NRST; i++) begin : g_cand
      assign cand[i+1] = rst_req[i] & ~rst_mask[i] & allow;
    end
    assign grant[NSRC-1] = cand[NSRC-1];
    for (genvar k = 0; k < NSRC-1; k++) begin : g_grant
      assign grant[k] = cand[k] & ~(|cand[NSRC-1:k+1]);
    end
  endgenerate
endmodule

// File: rtl/irqv_vector.sv
module irqv_vector
  import irqv_pkg::*;
#(
  parameter int NMI_VEC   = 'h24,
  parameter int RST_BASE  = 'h2C,
  parameter int RST_STEP  = 8,
  parameter int RST_CYC   = 11,
  parameter int JMP_CYC   = 10,
  parameter int CALL_XTRA = 7
) (
  input  logic [NSRC-1:0]   grant,
  input  logic              gen_call,
  input  logic [ADDR_W-1:0] gen_vec,
  output logic [ADDR_W-1:0] vec,
  output logic              push,
  output logic [CYC_W-1:0]  cyc
);
  localparam int CALL_CYC = JMP_CYC + CALL_XTRA;

  always_comb begin
    vec  = '0;
    push = 1'b0;
    cyc  = '0;
    if (grant[SRC_NMI]) begin
      vec  = ADDR_W'(NMI_VEC);
      push = 1'b1;
      cyc  = CYC_W'(RST_CYC);
    end
    for (int i = 0; i < NRST; i++) begin
      if (grant[i+1]) begin
        vec  = ADDR_W'(RST_BASE + RST_STEP * i);
        push = 1'b1;
        cyc  = CYC_W'(RST_CYC);
      end
    end
    if (grant[SRC_GEN]) begin
      vec  = gen_vec;
      push = gen_call;
      cyc  = gen_call ? CYC_W'(CALL_CYC) : CYC_W'(JMP_CYC);
    end
  end
endmodule

// File: rtl/irqv_enable.sv
module irqv_enable (
  input  logic clk,
  input  logic rst_n,
  input  logic ei,
  input  logic di,
  input  logic boundary,
  input  logic accept,
  output logic en,
  output logic allow
);
  localparam int HOLD = 2;
  localparam int CW   = $clog2(HOLD + 1);

  logic [CW-1:0] hold_cnt;

  assign allow = en & (hold_cnt != CW'(HOLD)) & ~ei & ~di;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      hold_cnt <= '0;
    end else if (di || accept) begin
      en       <= 1'b0;
      hold_cnt <= '0;
    end else if (ei) begin
      en       <= 1'b1;
      hold_cnt <= boundary ? CW'(HOLD - 1) : CW'(HOLD);
    end else if (boundary && hold_cnt != '0) begin
      hold_cnt <= hold_cnt - 1'b1;
    end
  end
endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irqv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_req,
  input  logic [NRST-1:0]   rst_req,
  input  logic [NRST-1:0]   rst_mask,
  input  logic              gen_req,
  input  logic              gen_is_call,
  input  logic [ADDR_W-1:0] gen_vector,
  input  logic              ei_pulse,
  input  logic              di_pulse,
  input  logic              boundary,
  output logic              int_en,
  output logic              take,
  output logic [NSRC-1:0]   take_src,
  output logic [ADDR_W-1:0] vector,
  output logic              push_pc,
  output logic [CYC_W-1:0]  cycles
);
  logic              allow, accept;
  logic [NSRC-1:0]   grant;
  logic [ADDR_W-1:0] vec_d;
  logic              push_d;
  logic [CYC_W-1:0]  cyc_d;

  irqv_enable u_enable (
    .clk(clk), .rst_n(rst_n), .ei(ei_pulse), .di(di_pulse),
    .boundary(boundary), .accept(accept), .en(int_en), .allow(allow)
  );

  irqv_arbiter u_arb (
    .nmi(nmi_req & boundary), .rst_req(rst_req & {NRST{boundary}}),
    .rst_mask(rst_mask), .gen_req(gen_req & boundary), .allow(allow),
    .grant(grant)
  );

  irqv_vector u_vec (
    .grant(grant), .gen_call(gen_is_call), .gen_vec(gen_vector),
    .vec(vec_d), .push(push_d), .cyc(cyc_d)
  );

  assign accept = |grant;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      take     <= 1'b0;
      take_src <= '0;
      vector   <= '0;
      push_pc  <= 1'b0;
      cycles   <= '0;
    end else begin
      take     <= accept;
      take_src <= grant;
      vector   <= accept ? vec_d : '0;
      push_pc  <= accept & push_d;
      cycles   <= accept ? cyc_d : '0;
    end
  end
endmodule

// File: rtl/irq_vector_unit_chk.sv
module irq_vector_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        nmi_req,
  input logic        boundary,
  input logic        ei_pulse,
  input logic        di_pulse,
  input logic        int_en,
  input logic        take,
  input logic [4:0]  take_src,
  input logic [15:0] vector,
  input logic        push_pc,
  input logic [4:0]  cycles
);
  assert_take_after_boundary_R11: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $past(boundary));
  assert_single_winner_R2: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> $countones(take_src) == 1);
  assert_accept_clears_en_R8: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> !int_en);
  assert_disable_now_R10: assert property (@(posedge clk) disable iff (!rst_n)
    di_pulse |=> !int_en);
  assert_nmi_always_R6: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && nmi_req |=> take && take_src[4]);
  assert_restart_cost_R4: assert property (@(posedge clk) disable iff (!rst_n)
    take && !take_src[0] |-> push_pc && cycles == 5'd11);
  assert_nmi_vector_R3: assert property (@(posedge clk) disable iff (!rst_n)
    take && take_src[4] |-> vector == 16'h0024);
  assert_needs_enable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    boundary && !nmi_req && !int_en |=> !take);
  assert_enable_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ei_pulse |=> !take || take_src[4]);
endmodule

bind irq_vector_unit irq_vector_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .boundary(boundary),
  .ei_pulse(ei_pulse), .di_pulse(di_pulse), .int_en(int_en), .take(take),
  .take_src(take_src), .vector(vector), .push_pc(push_pc), .cycles(cycles)
);

// File: tb/irq_vector_unit_bench.sv
`timescale 1ns/1ps
module irq_vector_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        nmi_req = 1'b0, gen_req = 1'b0, gen_is_call = 1'b0;
  logic [2:0]  rst_req = '0, rst_mask = '0;
  logic [15:0] gen_vector = '0;
  logic        ei_pulse = 1'b0, di_pulse = 1'b0, boundary = 1'b0;
  logic        int_en, take, push_pc;
  logic [4:0]  take_src, cycles;
  logic [15:0] vector;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  irq_vector_unit u_irq_vector_unit (
    .clk(clk), .rst_n(rst_n), .nmi_req(nmi_req), .rst_req(rst_req),
    .rst_mask(rst_mask), .gen_req(gen_req), .gen_is_call(gen_is_call),
    .gen_vector(gen_vector), .ei_pulse(ei_pulse), .di_pulse(di_pulse),
    .boundary(boundary), .int_en(int_en), .take(take), .take_src(take_src),
    .vector(vector), .push_pc(push_pc), .cycles(cycles)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_in();
    nmi_req = 0; rst_req = '0; gen_req = 0; ei_pulse = 0; di_pulse = 0; boundary = 0;
  endtask

  initial begin
    logic [4:0]  e_src;
    logic [15:0] e_vec;
    logic [4:0]  e_cyc;
    logic        e_push;
    @(negedge clk);
    tick(); tick();
    rst_n = 1;
    tick();
    check("R1 en after reset", int_en, 0);
    check("R1 take after reset", take, 0);

    // R11: requests without boundary are ignored
    ei_pulse = 1; boundary = 1; tick(); clear_in();
    nmi_req = 1; rst_req = 3'b111; gen_req = 1;
    tick(); tick();
    check("R11 no take without boundary", take, 0);
    check("R11 en kept without boundary", int_en, 1);
    clear_in();

    // Exhaustive sweep: requests, masks, enable state, general type
    for (int p = 0; p < 1024; p++) begin
      if (p[9]) begin
        ei_pulse = 1; boundary = 1; tick(); clear_in();
        check("R9 coincident boundary refuses", take, 0);
        check("R9 en set", int_en, 1);
      end else begin
        di_pulse = 1; tick(); clear_in();
        check("R10 en cleared", int_en, 0);
      end
      nmi_req = p[0]; rst_req = {p[1], p[2], p[3]}; gen_req = p[4];
      rst_mask = p[7:5]; gen_is_call = p[8]; gen_vector = 16'h4000 + 16'(p);
      boundary = 1;
      e_src = 0; e_vec = 0; e_cyc = 0; e_push = 0;
      if (p[0]) begin e_src = 5'b10000; e_vec = 16'h0024; e_cyc = 11; e_push = 1; end
      else if (p[9] && p[1] && !p[7]) begin e_src = 5'b01000; e_vec = 16'h003C; e_cyc = 11; e_push = 1; end
      else if (p[9] && p[2] && !p[6]) begin e_src = 5'b00100; e_vec = 16'h0034; e_cyc = 11; e_push = 1; end
      else if (p[9] && p[3] && !p[5]) begin e_src = 5'b00010; e_vec = 16'h002C; e_cyc = 11; e_push = 1; end
      else if (p[9] && p[4]) begin
        e_src = 5'b00001; e_vec = 16'h4000 + 16'(p);
        e_cyc = p[8] ? 5'd17 : 5'd10; e_push = p[8];
      end
      tick(); clear_in();
      check("R2 R6 R7 take", take, (e_src != 0));
      check("R2 winner", take_src, e_src);
      check("R3 R5 vector", vector, e_vec);
      check("R4 R5 cost", cycles, e_cyc);
      check("R4 R5 push", push_pc, e_push);
      check("R8 en after boundary", int_en, (e_src == 0) ? p[9] : 1'b0);
      tick();
      check("R11 single pulse", take, 0);
    end
    rst_mask = '0;

    // R9: early enable pulse, the next boundary refuses, the one after accepts
    di_pulse = 1; tick(); clear_in();
    ei_pulse = 1; tick(); clear_in();
    rst_req = 3'b100; boundary = 1; tick(); boundary = 0;
    check("R9 first boundary refuses", take, 0);
    boundary = 1; tick(); clear_in();
    check("R9 second boundary accepts", take, 1);
    check("R9 vector high", vector, 16'h003C);

    // R10: disable together with boundary refuses a maskable request
    ei_pulse = 1; boundary = 1; tick(); clear_in();
    di_pulse = 1; boundary = 1; rst_req = 3'b001; tick(); clear_in();
    check("R10 same-cycle disable refuses", take, 0);
    check("R10 en cleared", int_en, 0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R11 watchdog: actual not finished expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule